// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the write strobes that a host drives toward a flash array and turns multi-write unlock sequences into single-cycle operation requests for the embedded sequencer. Each write carries a 16-bit address and an 8-bit data value. Every command opens with a two-write prefix. The third write then picks a short command (program, identification entry or exit) or leads into a six-write path that ends in chip erase, sector erase, sector lock or the entry into bypass programming. Suspend and resume are single writes that need no prefix.

In bypass mode, every accepted write becomes a program request, whatever its address or code. Only a reset leaves this mode. The block also holds the identification-mode flag. While that flag is set, it answers read addresses with the manufacturer code, the device code or the lock status of the addressed sector. A write that arrives while the sequencer reports busy is dropped and leaves the decoder as it was.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, every request output is 0, `idMode` is 0 and bypass mode is off.
- R2: The writes (5555h,AAh), (2AAAh,55h), (5555h,A0h) and then any write (a,d) raise `pgmReq` for exactly the one cycle after that fourth write, with `reqAddr`=a and `reqData`=d.
- R3: A write that does not fit the sequence at its current step returns the decoder to idle and raises no request. A complete sequence that follows such a write is still recognised.
- R4: The prefix followed by (5555h,90h) sets `idMode`. The prefix followed by (5555h,F0h) clears it, and so does a lone write of F0h to any address when the decoder is idle.
- R5: While `idMode` is 1, `idRdData` is 1Fh for `rdAddr`=0 and `DEV_CODE` for `rdAddr`=1. For any other address whose low `SECT_OFF_W` bits equal 2, it is {7'b0,`sectLocked`}. All other addresses read 00h, and every address reads 00h while `idMode` is 0.
- R6: The six-write path prefix, 80h, prefix, then (5555h,10h) raises `chipEraseReq`. The same path ending in (5555h,40h) raises `lockReq`. In both cases `reqAddr`=5555h.
- R7: The six-write path ending in 30h at any address raises `sectEraseReq`, with `reqAddr` equal to that address.
- R8: From idle, B0h to any address raises `suspendReq`, and 30h to any address raises `resumeReq`. In both cases `reqAddr` carries the address.
- R9: The six-write path ending in (5555h,A0h) enters bypass mode. From then on, every accepted write raises only `pgmReq` with its own address and data, including the B0h, 30h, AAh and F0h codes, until `rstN` goes low.
- R10: A write with `busy`=1 raises no request, leaves `idMode` unchanged and does not move the sequence step.
- R11: At most one request output is 1 in any cycle, and a request is 1 only in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also the only exit from bypass mode |
| wrEn | input | 1 | Write strobe, one cycle per bus write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| busy | input | 1 | Sequencer busy; writes are ignored while high |
| rdAddr | input | ADDR_W | Read address for identification data |
| sectLocked | input | 1 | Lock state of the sector that `rdAddr` selects |
| pgmReq | output | 1 | Program request pulse |
| sectEraseReq | output | 1 | Sector erase request pulse |
| chipEraseReq | output | 1 | Chip erase request pulse |
| lockReq | output | 1 | Sector lock request pulse |
| suspendReq | output | 1 | Erase suspend request pulse |
| resumeReq | output | 1 | Erase resume request pulse |
| reqAddr | output | ADDR_W | Address that goes with the current request |
| reqData | output | DATA_W | Data that goes with the current request |
| idMode | output | 1 | Identification mode flag |
| idRdData | output | DATA_W | Identification or lock-status read data |

## Verification
Every directed sequence is followed once in its complete form and once broken at a chosen step. A request from the complete form that is absent after the break shows that the step check matters. The same command codes are sent from idle, after the prefix and in bypass mode: 30h must come out as resume, as sector erase and as program in those three places. Seeded random writes are drawn from the command addresses and codes mixed with free values, with occasional busy cycles and resets. This mix exposes wrong priority between codes, steps that fail to reset and writes that leak through while busy.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  localparam logic [15:0] ADDR_FIRST  = 16'h5555;
  localparam logic [15:0] ADDR_SECOND = 16'h2AAA;

  localparam int NUM_CODES = 10;
  localparam int C_AA = 0;
  localparam int C_55 = 1;
  localparam int C_80 = 2;
  localparam int C_A0 = 3;
  localparam int C_90 = 4;
  localparam int C_F0 = 5;
  localparam int C_10 = 6;
  localparam int C_30 = 7;
  localparam int C_40 = 8;
  localparam int C_B0 = 9;

  // code byte for index i sits at bits [8*i +: 8]
  localparam logic [NUM_CODES*8-1:0] CODE_VEC = {
    8'hB0, 8'h40, 8'h30, 8'h10, 8'hF0, 8'h90, 8'hA0, 8'h80, 8'h55, 8'hAA
  };

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E3, ST_E4, ST_E5, ST_BYP
  } ucd_state_t;

  typedef struct packed {
    logic [NUM_CODES-1:0] dataHit;
    logic                 atFirst;
    logic                 atSecond;
  } ucd_match_t;

  typedef struct packed {
    logic take;
    logic issuePgm;
    logic issueSect;
    logic issueChip;
    logic issueLock;
    logic issueSusp;
    logic issueRes;
    logic idSet;
    logic idClr;
  } ucd_strb_t;

endpackage

// File: rtl/ucd_ctrl.sv
module ucd_ctrl
  import ucd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       busy,
  input  ucd_match_t match,
  output ucd_strb_t  strb,
  output logic       inBypass
);

  ucd_state_t state, nextState;

  always_comb begin
    nextState = state;
    strb = '0;
    strb.take = wrEn && !busy;
    if (strb.take) begin
      unique case (state)
        ST_IDLE: begin
          if (match.atFirst && match.dataHit[C_AA]) nextState = ST_U1;
          else if (match.dataHit[C_B0]) strb.issueSusp = 1'b1;
          else if (match.dataHit[C_30]) strb.issueRes = 1'b1;
          else if (match.dataHit[C_F0]) strb.idClr = 1'b1;
        end
        ST_U1: nextState = (match.atSecond && match.dataHit[C_55]) ? ST_U2 : ST_IDLE;
        ST_U2: begin
          nextState = ST_IDLE;
          if (match.atFirst) begin
            if (match.dataHit[C_A0]) nextState = ST_PGM;
            else if (match.dataHit[C_80]) nextState = ST_E3;
            else if (match.dataHit[C_90]) strb.idSet = 1'b1;
            else if (match.dataHit[C_F0]) strb.idClr = 1'b1;
          end
        end
        ST_PGM: begin
          nextState = ST_IDLE;
          strb.issuePgm = 1'b1;
        end
        ST_E3: nextState = (match.atFirst && match.dataHit[C_AA]) ? ST_E4 : ST_IDLE;
        ST_E4: nextState = (match.atSecond && match.dataHit[C_55]) ? ST_E5 : ST_IDLE;
        ST_E5: begin
          nextState = ST_IDLE;
          if (match.dataHit[C_30]) strb.issueSect = 1'b1;
          else if (match.atFirst) begin
            if (match.dataHit[C_10]) strb.issueChip = 1'b1;
            else if (match.dataHit[C_40]) strb.issueLock = 1'b1;
            else if (match.dataHit[C_A0]) nextState = ST_BYP;
          end
        end
        ST_BYP: strb.issuePgm = 1'b1;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign inBypass = (state == ST_BYP);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> $stable(state));

  p_bypass_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BYP) |=> (state == ST_BYP));

  p_prefix_from_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_U1) |-> ($past(state) == ST_IDLE || $past(state) == ST_U1));

endmodule

// File: rtl/ucd_datapath.sv
module ucd_datapath
  import ucd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SECT_OFF_W = 12,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ucd_strb_t         strb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              sectLocked,
  output ucd_match_t        match,
  output logic              pgmReq,
  output logic              sectEraseReq,
  output logic              chipEraseReq,
  output logic              lockReq,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              idMode,
  output logic [DATA_W-1:0] idRdData
);

  localparam logic [SECT_OFF_W-1:0] LOCK_OFF = SECT_OFF_W'(2);

  logic anyIssue;
  logic anyReq;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign match.dataHit[i] = (wrData[7:0] == CODE_VEC[8*i +: 8]);
  end
  assign match.atFirst  = (wrAddr[15:0] == ADDR_FIRST);
  assign match.atSecond = (wrAddr[15:0] == ADDR_SECOND);

  assign anyIssue = strb.issuePgm | strb.issueSect | strb.issueChip |
                    strb.issueLock | strb.issueSusp | strb.issueRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgmReq       <= 1'b0;
      sectEraseReq <= 1'b0;
      chipEraseReq <= 1'b0;
      lockReq      <= 1'b0;
      suspendReq   <= 1'b0;
      resumeReq    <= 1'b0;
      reqAddr      <= '0;
      reqData      <= '0;
      idMode       <= 1'b0;
    end else begin
      pgmReq       <= strb.take & strb.issuePgm;
      sectEraseReq <= strb.take & strb.issueSect;
      chipEraseReq <= strb.take & strb.issueChip;
      lockReq      <= strb.take & strb.issueLock;
      suspendReq   <= strb.take & strb.issueSusp;
      resumeReq    <= strb.take & strb.issueRes;
      if (strb.take && anyIssue) begin
        reqAddr <= wrAddr;
        reqData <= wrData;
      end
      if (strb.take && strb.idSet)      idMode <= 1'b1;
      else if (strb.take && strb.idClr) idMode <= 1'b0;
    end
  end

  always_comb begin
    idRdData = '0;
    if (idMode) begin
      if (rdAddr == ADDR_W'(0))                   idRdData = DATA_W'(MFR_CODE);
      else if (rdAddr == ADDR_W'(1))              idRdData = DATA_W'(DEV_CODE);
      else if (rdAddr[SECT_OFF_W-1:0] == LOCK_OFF) idRdData = DATA_W'(sectLocked);
    end
  end

  assign anyReq = pgmReq | sectEraseReq | chipEraseReq | lockReq | suspendReq | resumeReq;

  p_one_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pgmReq, sectEraseReq, chipEraseReq, lockReq, suspendReq, resumeReq}));

  p_req_after_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> $past(strb.take));

  p_id_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.take) |-> $stable(idMode));

  p_id_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !idMode |-> (idRdData == '0));

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SECT_OFF_W = 12,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              sectLocked,
  output logic              pgmReq,
  output logic              sectEraseReq,
  output logic              chipEraseReq,
  output logic              lockReq,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              idMode,
  output logic [DATA_W-1:0] idRdData
);

  ucd_match_t match;
  ucd_strb_t  strb;
  logic       inBypass;

  ucd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .busy     (busy),
    .match    (match),
    .strb     (strb),
    .inBypass (inBypass)
  );

  ucd_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SECT_OFF_W (SECT_OFF_W),
    .MFR_CODE   (MFR_CODE),
    .DEV_CODE   (DEV_CODE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .strb         (strb),
    .rdAddr       (rdAddr),
    .sectLocked   (sectLocked),
    .match        (match),
    .pgmReq       (pgmReq),
    .sectEraseReq (sectEraseReq),
    .chipEraseReq (chipEraseReq),
    .lockReq      (lockReq),
    .suspendReq   (suspendReq),
    .resumeReq    (resumeReq),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .idMode       (idMode),
    .idRdData     (idRdData)
  );

  p_bypass_pgm_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && inBypass && wrEn && !busy) |-> (pgmReq && !suspendReq && !resumeReq));

  p_req_payload_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && pgmReq |-> (reqData == $past(wrData) && reqAddr == $past(wrAddr)));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !$past(rstN) |-> (!pgmReq && !idMode && !inBypass));

endmodule

// File: tb/unlock_cmd_decoder_bench.sv
`timescale 1ns/1ps
module unlock_cmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        busy = 1'b0;
  logic [15:0] rdAddr = '0;
  logic        sectLocked = 1'b0;
  logic pgmReq, sectEraseReq, chipEraseReq, lockReq, suspendReq, resumeReq;
  logic [15:0] reqAddr;
  logic [7:0]  reqData, idRdData;
  logic        idMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench reference state
  int ms = 0;
  int mid = 0;
  int gotKind;

  always #2 clk = ~clk;

  unlock_cmd_decoder u_unlock_cmd_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .rdAddr(rdAddr), .sectLocked(sectLocked),
    .pgmReq(pgmReq), .sectEraseReq(sectEraseReq), .chipEraseReq(chipEraseReq),
    .lockReq(lockReq), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .reqAddr(reqAddr), .reqData(reqData), .idMode(idMode), .idRdData(idRdData)
  );

  // request kinds: 0 none, 1 program, 2 sector erase, 3 chip erase,
  // 4 lock, 5 suspend, 6 resume, 7 more than one
  function automatic int kindNow();
    int n = int'(pgmReq) + int'(sectEraseReq) + int'(chipEraseReq) +
            int'(lockReq) + int'(suspendReq) + int'(resumeReq);
    if (n > 1) return 7;
    if (pgmReq) return 1;
    if (sectEraseReq) return 2;
    if (chipEraseReq) return 3;
    if (lockReq) return 4;
    if (suspendReq) return 5;
    if (resumeReq) return 6;
    return 0;
  endfunction

  function automatic logic [7:0] expRd(input logic [15:0] a, input logic lk, input int idm);
    if (idm == 0) return 8'h00;
    if (a == 16'h0000) return 8'h1F;
    if (a == 16'h0001) return 8'hC0;
    if (a[11:0] == 12'h002) return {7'b0, lk};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference step from the requirements, returns the expected request kind
  task automatic modelStep(input logic [15:0] a, input logic [7:0] d, input logic b,
                           output int kind);
    kind = 0;
    if (b) return;
    case (ms)
      0: begin
        if (a == 16'h5555 && d == 8'hAA) ms = 1;
        else if (d == 8'hB0) kind = 5;
        else if (d == 8'h30) kind = 6;
        else if (d == 8'hF0) mid = 0;
      end
      1: ms = (a == 16'h2AAA && d == 8'h55) ? 2 : 0;
      2: begin
        ms = 0;
        if (a == 16'h5555) begin
          if (d == 8'hA0) ms = 3;
          else if (d == 8'h80) ms = 4;
          else if (d == 8'h90) mid = 1;
          else if (d == 8'hF0) mid = 0;
        end
      end
      3: begin kind = 1; ms = 0; end
      4: ms = (a == 16'h5555 && d == 8'hAA) ? 5 : 0;
      5: ms = (a == 16'h2AAA && d == 8'h55) ? 6 : 0;
      6: begin
        ms = 0;
        if (d == 8'h30) kind = 2;
        else if (a == 16'h5555 && d == 8'h10) kind = 3;
        else if (a == 16'h5555 && d == 8'h40) kind = 4;
        else if (a == 16'h5555 && d == 8'hA0) ms = 7;
      end
      default: kind = 1;
    endcase
  endtask

  // one bus write, checked against the reference; called at a falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic b, input string tag);
    int ek;
    modelStep(a, d, b, ek);
    wrEn = 1'b1; wrAddr = a; wrData = d; busy = b;
    @(negedge clk);
    wrEn = 1'b0; busy = 1'b0;
    gotKind = kindNow();
    chk({tag, " kind"}, gotKind, ek);
    if (ek != 0) begin
      chk({tag, " addr"}, reqAddr, a);
      chk({tag, " data"}, reqData, d);
    end
    chk({tag, " idMode"}, idMode, mid);
  endtask

  task automatic prefix(input string tag);
    wr(16'h5555, 8'hAA, 1'b0, tag);
    wr(16'h2AAA, 8'h55, 1'b0, tag);
  endtask

  task automatic sixPath(input string tag);
    prefix(tag);
    wr(16'h5555, 8'h80, 1'b0, tag);
    prefix(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    ms = 0; mid = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 reset req", kindNow(), 0);
    chk("R1 reset id", idMode, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", kindNow(), 0);

    // R2 program
    prefix("R2");
    wr(16'h5555, 8'hA0, 1'b0, "R2");
    wr(16'h1234, 8'h5A, 1'b0, "R2 prog");
    chk("R2 pgm", gotKind, 1);
    @(negedge clk);
    chk("R2 one cycle", kindNow(), 0);

    // R3 broken sequences
    wr(16'h5555, 8'hAA, 1'b0, "R3");
    wr(16'h2AAB, 8'h55, 1'b0, "R3 bad addr");
    wr(16'h5555, 8'hA0, 1'b0, "R3");
    wr(16'h0040, 8'h77, 1'b0, "R3 no pgm");
    chk("R3 break", gotKind, 0);
    prefix("R3");
    wr(16'h5555, 8'hA0, 1'b0, "R3");
    wr(16'h0040, 8'h77, 1'b0, "R3 recover");
    chk("R3 recover pgm", gotKind, 1);

    // R4/R5 identification
    prefix("R4");
    wr(16'h5555, 8'h90, 1'b0, "R4 enter");
    chk("R4 id set", idMode, 1);
    rdAddr = 16'h0000; #1 chk("R5 mfr", idRdData, 8'h1F);
    rdAddr = 16'h0001; #1 chk("R5 dev", idRdData, 8'hC0);
    rdAddr = 16'h3002; sectLocked = 1'b1; #1 chk("R5 lock1", idRdData, 8'h01);
    sectLocked = 1'b0; #1 chk("R5 lock0", idRdData, 8'h00);
    rdAddr = 16'h0005; #1 chk("R5 other", idRdData, 8'h00);
    @(negedge clk);
    wr(16'h7777, 8'hF0, 1'b0, "R4 lone exit");
    chk("R4 id clr", idMode, 0);
    rdAddr = 16'h0000; #1 chk("R5 off", idRdData, 8'h00);
    @(negedge clk);
    prefix("R4"); wr(16'h5555, 8'h90, 1'b0, "R4");
    prefix("R4"); wr(16'h5555, 8'hF0, 1'b0, "R4 seq exit");
    chk("R4 seq clr", idMode, 0);

    // R6/R7 six-write path
    sixPath("R6"); wr(16'h5555, 8'h10, 1'b0, "R6 chip");
    chk("R6 chip", gotKind, 3);
    sixPath("R6"); wr(16'h5555, 8'h40, 1'b0, "R6 lock");
    chk("R6 lock", gotKind, 4);
    sixPath("R7"); wr(16'h8ABC, 8'h30, 1'b0, "R7 sect");
    chk("R7 sect", gotKind, 2);
    chk("R7 addr", reqAddr, 16'h8ABC);

    // R8 suspend / resume
    wr(16'h0123, 8'hB0, 1'b0, "R8 susp");
    chk("R8 susp", gotKind, 5);
    wr(16'hC000, 8'h30, 1'b0, "R8 res");
    chk("R8 res", gotKind, 6);

    // R10 busy
    prefix("R10");
    wr(16'h5555, 8'hA0, 1'b1, "R10 busy drop");
    wr(16'h0001, 8'hB0, 1'b1, "R10 busy susp");
    chk("R10 no req", gotKind, 0);
    wr(16'h5555, 8'hA0, 1'b0, "R10");
    wr(16'h0202, 8'h33, 1'b0, "R10 held step");
    chk("R10 pgm", gotKind, 1);

    // R9 bypass
    sixPath("R9"); wr(16'h5555, 8'hA0, 1'b0, "R9 enter");
    wr(16'h0010, 8'hB0, 1'b0, "R9 B0");
    chk("R9 B0 pgm", gotKind, 1);
    wr(16'h0011, 8'h30, 1'b0, "R9 30");
    chk("R9 30 pgm", gotKind, 1);
    wr(16'h5555, 8'hAA, 1'b0, "R9 AA");
    chk("R9 AA pgm", gotKind, 1);
    wr(16'h0012, 8'hF0, 1'b0, "R9 F0");
    doReset();
    wr(16'h0013, 8'hB0, 1'b0, "R9 exit");
    chk("R9 exit susp", gotKind, 5);

    // constrained random (R11 via kind 7 mismatch)
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      logic        b;
      int r;
      r = int'($urandom_range(0, 9));
      a = (r < 4) ? 16'h5555 : (r < 7) ? 16'h2AAA : 16'($urandom);
      r = int'($urandom_range(0, 13));
      case (r)
        0, 1: d = 8'hAA; 2, 3: d = 8'h55; 4: d = 8'h80; 5: d = 8'hA0;
        6: d = 8'h90; 7: d = 8'hF0; 8: d = 8'h10; 9: d = 8'h30;
        10: d = 8'h40; 11: d = 8'hB0; default: d = 8'($urandom);
      endcase
      b = ($urandom_range(0, 7) == 0);
      wr(a, d, b, "R11 random");
      if ($urandom_range(0, 79) == 0) doReset();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule